// File: doc/BRIEF.md
# Multiplexed GPIO Port with Priority Pin Ownership

This block is one parameterizable general-purpose I/O port. Each pin has an output latch bit, a direction bit and an open-drain bit. Software reaches these through a small synchronous write / combinational read register interface. For every pin the block decides who owns the output driver: a debug port (for a fixed group of pins, while debug mode is on), then the peripheral slots in a fixed priority order, then the port latch. A peripheral takes the pin only while it is both enabled and requesting drive. When it is enabled but not requesting, the port keeps the pin.

The pad input fans out to every peripheral input tap on the pin, and peripherals have no priority on the input side. Peripheral slots marked as loopback class may instead see the latch value when the pin is a port-owned output. This lets software stimulate interrupt, timer-clock, capture or fault inputs without external wiring. Serial-class slots always see the pad. The pad value can be read through a two-flop synchronizer at a dedicated read address.

Top module: `gpio_mux_port`

## Requirements
- R1: When the port owns a pin, the direction bit is 0 (output) and the open-drain bit is 1, the pad driver is enabled only while the latch bit is 0 (`pad_oe` = 1, `pad_out` = 0). A latch bit of 1 releases the pin (`pad_oe` = 0).
- R2: After reset the open-drain register (address 2) reads 0, so port-owned outputs drive both levels.
- R3: A peripheral slot with enable and drive request both 1 owns the pin. `pad_oe` is 1 and `pad_out` follows that slot's output data, whatever the direction and latch bits hold. The pad value stays readable through the port read.
- R4: A peripheral that is enabled but not requesting drive leaves the pin to the port. The latch and direction bits then decide `pad_out` and `pad_oe`.
- R5: Among requesting peripherals, slot 0 has the highest priority and each higher index ranks lower. The port latch ranks below every slot. At most one slot is granted a pin.
- R6: The pad value reaches every peripheral input tap of a pin at the same time, with no priority between the taps.
- R7: A loopback-class slot that owns a pin sees the pad value on its input, never the latch (no loop-through).
- R8: A loopback-class slot sees the latch bit on its input when the pin is a port-owned output (direction 0). Otherwise it sees the pad.
- R9: A serial-class slot (bit clear in `LOOPBACK_MASK`) always sees the pad value, whatever the latch and direction bits hold.
- R10: The debug-enable bit (address 3, bit 0) resets to 1. While it is 1, the pins in `DBG_MASK` take `dbg_oe`/`dbg_out` on the pad. Writing 0 returns those pins to normal arbitration. `dbg_in` carries the pad value on the `DBG_MASK` pins and 0 elsewhere.
- R11: Reading address 4 returns the pad value through two flops. A pad change made between two rising edges shows up after the second rising edge, not after the first.
- R12: The direction register (address 1) resets to all ones (all inputs) and the latch (address 0) resets to 0. Addresses 0 to 3 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 latch, 1 direction, 2 open-drain, 3 debug enable) |
| wr_data | input | NPINS | Write data |
| rd_addr | input | 3 | Read address (0 to 3 as for writes, 4 synchronized pad) |
| rd_data | output | NPINS | Read data |
| periph_en | input | NPERIPH x NPINS | Peripheral enable per slot and pin |
| periph_req | input | NPERIPH x NPINS | Peripheral drive request per slot and pin |
| periph_out | input | NPERIPH x NPINS | Peripheral output data per slot and pin |
| periph_in | output | NPERIPH x NPINS | Peripheral input taps per slot and pin |
| dbg_oe | input | NPINS | Debug port output enable |
| dbg_out | input | NPINS | Debug port output data |
| dbg_in | output | NPINS | Debug port input tap |
| pad_in | input | NPINS | Pad input level |
| pad_out | output | NPINS | Pad output level |
| pad_oe | output | NPINS | Pad driver enable |

## Verification
A wrong ownership decision shows on `pad_oe`/`pad_out` in the same cycle as the request or register change. These outputs depend only on the registers and the request inputs. A corrupted latch, direction, open-drain or debug bit appears at the pads right after the write edge, and also on the loopback-class input taps. A synchronizer fault shows as a port read that changes one edge too early or too late, so the bench samples the read on both sides of the second edge.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    typedef enum logic [2:0] {
        ADDR_LATCH  = 3'd0,
        ADDR_DIR    = 3'd1,
        ADDR_ODRAIN = 3'd2,
        ADDR_DBG    = 3'd3,
        ADDR_PORT   = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q, stage2_q;

    always_ff @(posedge clk) begin
        stage1_q <= async_in;
        stage2_q <= stage1_q;
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_pin_arbiter.sv
module gpio_pin_arbiter #(
    parameter int                 NPERIPH       = 3,
    parameter logic [NPERIPH-1:0] LOOPBACK_MASK = '0,
    parameter bit                 IS_DBG_PIN    = 1'b0
) (
    input  logic               lat,
    input  logic               dir_in,
    input  logic               odrain,
    input  logic               dbg_en,
    input  logic [NPERIPH-1:0] p_en,
    input  logic [NPERIPH-1:0] p_req,
    input  logic [NPERIPH-1:0] p_out,
    input  logic               dbg_oe,
    input  logic               dbg_out,
    input  logic               pad_in,
    output logic               pad_out,
    output logic               pad_oe,
    output logic [NPERIPH-1:0] p_in,
    output logic [NPERIPH-1:0] grant
);
    logic dbg_own;
    logic taken;

    assign dbg_own = IS_DBG_PIN && dbg_en;

    // fixed priority: lowest slot index wins
    always_comb begin
        grant = '0;
        taken = 1'b0;
        for (int p = 0; p < NPERIPH; p++) begin
            if (!taken && p_en[p] && p_req[p]) begin
                grant[p] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    always_comb begin
        if (dbg_own) begin
            pad_oe  = dbg_oe;
            pad_out = dbg_out;
        end else if (taken) begin
            pad_oe  = 1'b1;
            pad_out = |(grant & p_out);
        end else begin
            pad_oe  = !dir_in && (!odrain || !lat);
            pad_out = lat;
        end
    end

    // input taps: loopback only when the port itself drives the pin
    always_comb begin
        for (int p = 0; p < NPERIPH; p++) begin
            if (LOOPBACK_MASK[p] && !dbg_own && !taken && !dir_in)
                p_in[p] = lat;
            else
                p_in[p] = pad_in;
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int                 NPINS         = 8,
    parameter int                 NPERIPH       = 3,
    parameter logic [NPERIPH-1:0] LOOPBACK_MASK = 3'b100,
    parameter logic [NPINS-1:0]   DBG_MASK      = 8'hC0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_addr,
    input  logic [NPINS-1:0]                wr_data,
    input  logic [2:0]                      rd_addr,
    output logic [NPINS-1:0]                rd_data,
    input  logic [NPERIPH-1:0][NPINS-1:0]   periph_en,
    input  logic [NPERIPH-1:0][NPINS-1:0]   periph_req,
    input  logic [NPERIPH-1:0][NPINS-1:0]   periph_out,
    output logic [NPERIPH-1:0][NPINS-1:0]   periph_in,
    input  logic [NPINS-1:0]                dbg_oe,
    input  logic [NPINS-1:0]                dbg_out,
    output logic [NPINS-1:0]                dbg_in,
    input  logic [NPINS-1:0]                pad_in,
    output logic [NPINS-1:0]                pad_out,
    output logic [NPINS-1:0]                pad_oe
);
    localparam logic [NPINS-1:0] DIR_RESET = {NPINS{1'b1}};

    typedef struct packed {
        logic [NPINS-1:0] lat;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] od;
        logic             dbg_en;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0][NPERIPH-1:0] grant_all;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_LATCH:  regs_d.lat    = wr_data;
                ADDR_DIR:    regs_d.dir    = wr_data;
                ADDR_ODRAIN: regs_d.od     = wr_data;
                ADDR_DBG:    regs_d.dbg_en = wr_data[0];
                default:     regs_d        = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.lat    <= '0;
            regs_q.dir    <= DIR_RESET;
            regs_q.od     <= '0;
            regs_q.dbg_en <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(rd_addr))
            ADDR_LATCH:  rd_data = regs_q.lat;
            ADDR_DIR:    rd_data = regs_q.dir;
            ADDR_ODRAIN: rd_data = regs_q.od;
            ADDR_DBG:    rd_data = {{(NPINS-1){1'b0}}, regs_q.dbg_en};
            ADDR_PORT:   rd_data = pad_sync;
            default:     rd_data = '0;
        endcase
    end

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    assign dbg_in = pad_in & DBG_MASK;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [NPERIPH-1:0] en_col, req_col, out_col, in_col;

        for (genvar p = 0; p < NPERIPH; p++) begin : g_slot
            assign en_col[p]       = periph_en[p][i];
            assign req_col[p]      = periph_req[p][i];
            assign out_col[p]      = periph_out[p][i];
            assign periph_in[p][i] = in_col[p];
        end

        gpio_pin_arbiter #(
            .NPERIPH       (NPERIPH),
            .LOOPBACK_MASK (LOOPBACK_MASK),
            .IS_DBG_PIN    (DBG_MASK[i])
        ) u_arb (
            .lat     (regs_q.lat[i]),
            .dir_in  (regs_q.dir[i]),
            .odrain  (regs_q.od[i]),
            .dbg_en  (regs_q.dbg_en),
            .p_en    (en_col),
            .p_req   (req_col),
            .p_out   (out_col),
            .dbg_oe  (dbg_oe[i]),
            .dbg_out (dbg_out[i]),
            .pad_in  (pad_in[i]),
            .pad_out (pad_out[i]),
            .pad_oe  (pad_oe[i]),
            .p_in    (in_col),
            .grant   (grant_all[i])
        );
    end
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
    parameter int                 NPINS         = 8,
    parameter int                 NPERIPH       = 3,
    parameter logic [NPERIPH-1:0] LOOPBACK_MASK = 3'b100,
    parameter logic [NPINS-1:0]   DBG_MASK      = 8'hC0
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NPINS-1:0]                lat,
    input logic [NPINS-1:0]                dir,
    input logic [NPINS-1:0]                od,
    input logic                            dbg_en,
    input logic [NPINS-1:0][NPERIPH-1:0]   grant,
    input logic [NPERIPH-1:0][NPINS-1:0]   periph_in,
    input logic [NPINS-1:0]                pad_in,
    input logic [NPINS-1:0]                pad_oe,
    input logic [2:0]                      rd_addr,
    input logic [NPINS-1:0]                rd_data
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // R1: port-owned open-drain output with latch 1 releases the pad
        assert_od_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (!(DBG_MASK[i] && dbg_en) && grant[i] == '0 && !dir[i] && od[i] && lat[i])
            |-> !pad_oe[i]);

        // R3: a granted peripheral always enables the driver
        assert_periph_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!(DBG_MASK[i] && dbg_en) && grant[i] != '0) |-> pad_oe[i]);

        // R5: at most one slot owns a pin
        assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[i]));

        for (genvar p = 0; p < NPERIPH; p++) begin : g_slot
            if (!LOOPBACK_MASK[p]) begin : g_serial
                // R9: serial-class taps follow the pad
                assert_serial_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    periph_in[p][i] == pad_in[i]);
            end else begin : g_loop
                // R7: an owning loopback slot never sees its own latch path
                assert_no_loop_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    grant[i][p] |-> periph_in[p][i] == pad_in[i]);
            end
        end
    end

    // R11: port read lags the pad by two edges
    assert_sync_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd4) |-> rd_data == $past(pad_in, 2));

    // R10 and R12: reset values seen on the first enabled edge
    assert_dbg_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> dbg_en);
    assert_dir_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&dir && od == '0));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
    .NPINS         (NPINS),
    .NPERIPH       (NPERIPH),
    .LOOPBACK_MASK (LOOPBACK_MASK),
    .DBG_MASK      (DBG_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat       (regs_q.lat),
    .dir       (regs_q.dir),
    .od        (regs_q.od),
    .dbg_en    (regs_q.dbg_en),
    .grant     (grant_all),
    .periph_in (periph_in),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/gpio_mux_port_test.sv
module gpio_mux_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS   = 8;
    localparam int NPERIPH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [NPINS-1:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [NPINS-1:0] rd_data;
    logic [NPERIPH-1:0][NPINS-1:0] periph_en, periph_req, periph_out, periph_in;
    logic [NPINS-1:0] dbg_oe, dbg_out, dbg_in, pad_in, pad_out, pad_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mux_port #(
        .NPINS(NPINS), .NPERIPH(NPERIPH),
        .LOOPBACK_MASK(3'b100), .DBG_MASK(8'hC0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .periph_en(periph_en), .periph_req(periph_req),
        .periph_out(periph_out), .periph_in(periph_in),
        .dbg_oe(dbg_oe), .dbg_out(dbg_out), .dbg_in(dbg_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0; rd_addr = '0;
        periph_en = '0; periph_req = '0; periph_out = '0;
        dbg_oe = '0; dbg_out = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [NPINS-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NPINS-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [NPINS-1:0] v;
        do_reset();
        check("R12", "pad_oe after reset", pad_oe, 8'h00);
        rd(3'd0, v); check("R12", "latch reset", v, 8'h00);
        rd(3'd1, v); check("R12", "dir reset", v, 8'hFF);
        rd(3'd2, v); check("R2", "open-drain reset", v, 8'h00);
        rd(3'd3, v); check("R10", "debug enable reset", v, 8'h01);
        wr(3'd0, 8'hA5); rd(3'd0, v); check("R12", "latch readback", v, 8'hA5);
        wr(3'd2, 8'h3C); rd(3'd2, v); check("R12", "open-drain readback", v, 8'h3C);
    endtask

    task automatic t_open_drain();
        do_reset();
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'hA5);
        check("R2", "push-pull oe", pad_oe, 8'hFF);
        check("R2", "push-pull out", pad_out, 8'hA5);
        wr(3'd2, 8'hFF);
        check("R1", "open-drain oe", pad_oe, 8'h5A);
        check("R1", "open-drain drives low", pad_out & pad_oe, 8'h00);
    endtask

    task automatic t_priority();
        do_reset();
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'hFF);
        periph_en[0][0] = 1; periph_req[0][0] = 1; periph_out[0][0] = 1;
        periph_en[1][0] = 1; periph_req[1][0] = 1; periph_out[1][0] = 0;
        #1 check("R5", "slot0 wins", pad_out[0], 1'b1);
        periph_req[0][0] = 0;
        #1 check("R5", "slot1 after slot0 drops", pad_out[0], 1'b0);
        periph_req[1][0] = 0;
        #1 check("R5", "port lowest", pad_out[0], 1'b1);
        // R4: enabled without request leaves port in control
        periph_en[0][1] = 1; periph_out[0][1] = 0;
        #1 check("R4", "enabled idle peripheral yields", {pad_oe[1], pad_out[1]}, 2'b11);
    endtask

    task automatic t_periph_own();
        logic [NPINS-1:0] v;
        do_reset();
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h00);
        periph_en[1][2] = 1; periph_req[1][2] = 1; periph_out[1][2] = 1;
        #1 check("R3", "peripheral owns input pin oe", pad_oe[2], 1'b1);
        check("R3", "peripheral data on pad", pad_out[2], 1'b1);
        pad_in = 8'h04;
        rd_addr = 3'd4;
        @(negedge clk);
        rd(3'd4, v); check("R11", "one edge: not yet", v, 8'h00);
        @(negedge clk);
        rd(3'd4, v); check("R3", "pin readable while peripheral drives", v, 8'h04);
    endtask

    task automatic t_inputs();
        do_reset();
        wr(3'd3, 8'h00);
        pad_in = 8'h3C;
        #1 check("R6", "slot0 tap", periph_in[0], 8'h3C);
        check("R6", "slot1 tap", periph_in[1], 8'h3C);
        check("R6", "slot2 tap", periph_in[2], 8'h3C);
        wr(3'd1, 8'h0F);
        wr(3'd0, 8'h5A);
        pad_in = 8'hC3;
        #1 check("R8", "loopback sees latch on outputs", periph_in[2], 8'h53);
        check("R9", "serial ignores latch", periph_in[0], 8'hC3);
        periph_en[2][4] = 1; periph_req[2][4] = 1;
        #1 check("R7", "owning loopback slot sees pad", periph_in[2], 8'h43);
    endtask

    task automatic t_debug();
        do_reset();
        wr(3'd1, 8'h00);
        dbg_oe = 8'hC0; dbg_out = 8'h80; pad_in = 8'hFF;
        #1 check("R10", "debug pins owned, oe", pad_oe, 8'hFF);
        check("R10", "debug data", pad_out, 8'h80);
        check("R10", "debug input tap", dbg_in, 8'hC0);
        dbg_oe = 8'h40;
        #1 check("R10", "debug oe follows", pad_oe, 8'h7F);
        wr(3'd3, 8'h00);
        check("R10", "released to port", {pad_oe, pad_out}, 16'hFF00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_open_drain();
        t_priority();
        t_periph_own();
        t_inputs();
        t_debug();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule